// File: doc/BRIEF.md
# Base-Displacement Effective Address Generator

This block sits between instruction fetch and the operand path of a pipeline that runs a classic four-byte mainframe-style instruction word. A strobed instruction word is decoded to find its format. The block then reads up to two general-purpose registers through two combinational read ports. It adds a base value, an index value (register-indexed format only) and a zero-extended 12-bit displacement. One clock after the strobe it presents the result with the decoded register fields.

Register number 0 in a base or index field means "no register", so that operand adds zero. For the shift opcode the sum is not a memory address. It leaves the block as a 6-bit shift count on its own output. Opcodes outside the supported table are flagged as illegal, and both the address and the count are forced to zero.

Top module: `eff_addr_gen`

## Requirements
- R1: When `in_valid` is high at a rising edge, every result output is updated at that edge and `out_valid` is high for that one cycle. Without a strobe, `out_valid` is low and all other outputs hold their values.
- R2: Instruction fields are the opcode in bits 31:24, the first register in bits 23:20, the second nibble in bits 19:16, the base in bits 15:12 and the displacement in bits 11:0. `rd_base_idx` carries bits 15:12 and `rd_idx_idx` carries bits 19:16, both combinationally from `instr`. The three register nibbles appear registered on `r1_fld`, `r2_fld` and `base_fld`.
- R3: The displacement is zero-extended, and the result is base + index + displacement modulo 2^32.
- R4: A base field of 0 contributes zero, whatever `rd_base_data` holds.
- R5: In register-indexed format, an index field of 0 contributes zero, whatever `rd_idx_data` holds.
- R6: In register-storage format, the second nibble is a register operand and is never added, whatever `rd_idx_data` holds.
- R7: Opcode 0x58 gives `fmt` = 2'b01 (register-indexed) with `is_address` high. Opcode 0x98 gives `fmt` = 2'b10 (register-storage) with `is_address` high.
- R8: Opcode 0x89 gives `fmt` = 2'b10 with `is_count` high. `shift_cnt` is bits 5:0 of the sum and `eff_addr` is zero.
- R9: Any other opcode gives `illegal` high, `fmt` = 2'b00, and `eff_addr`, `shift_cnt`, `is_address` and `is_count` all zero. On a valid result, exactly one of `is_address`, `is_count` and `illegal` is high.
- R10: While `rst` is high, every output register is zero.
- R11: When `is_address` is high, `shift_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| rd_base_idx | output | 4 | Register number for the base read port |
| rd_base_data | input | 32 | Contents of the register named by `rd_base_idx` |
| rd_idx_idx | output | 4 | Register number for the index read port |
| rd_idx_data | input | 32 | Contents of the register named by `rd_idx_idx` |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| eff_addr | output | 32 | Effective address |
| shift_cnt | output | 6 | Shift count for the shift opcode |
| is_address | output | 1 | Result is a memory address |
| is_count | output | 1 | Result is a shift count |
| illegal | output | 1 | Unsupported opcode |
| fmt | output | 2 | Format tag: 00 none, 01 register-indexed, 10 register-storage |
| r1_fld | output | 4 | First register field |
| r2_fld | output | 4 | Index or second register field |
| base_fld | output | 4 | Base register field |

## Verification
The base and index additions can name the same register in one instruction. In that case both read ports fetch the same value in the same cycle, and the sum must count it twice. The bench provokes this with register-indexed words whose index and base nibbles are equal, and it compares the result with twice the register plus the displacement. A second collision pairs a nonzero register operand in the register-storage second nibble with a large value in that register. The check is that only the base and the displacement reach the sum.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_RX   = 2'b01,
    FMT_RS   = 2'b10
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic use_index;
    logic is_shift;
    logic bad_op;
  } dec_t;

  localparam logic [7:0] OPC_LOAD     = 8'h58;
  localparam logic [7:0] OPC_LOAD_MUL = 8'h98;
  localparam logic [7:0] OPC_SHIFT_L  = 8'h89;
endpackage

// File: rtl/eag_decode.sv
module eag_decode
  import eag_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);
  always_comb begin
    dec = '{fmt: FMT_NONE, use_index: 1'b0, is_shift: 1'b0, bad_op: 1'b1};
    case (opcode)
      OPC_LOAD:     dec = '{fmt: FMT_RX, use_index: 1'b1, is_shift: 1'b0, bad_op: 1'b0};
      OPC_LOAD_MUL: dec = '{fmt: FMT_RS, use_index: 1'b0, is_shift: 1'b0, bad_op: 1'b0};
      OPC_SHIFT_L:  dec = '{fmt: FMT_RS, use_index: 1'b0, is_shift: 1'b1, bad_op: 1'b0};
      default: ;
    endcase
  end
endmodule

// File: rtl/eag_operand.sv
module eag_operand #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4
) (
  input  logic [REG_W-1:0]  fld,
  input  logic              en,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] val
);
  always_comb val = (en && (fld != '0)) ? data : '0;
endmodule

// File: rtl/eag_sum.sv
module eag_sum #(
  parameter int DATA_W = 32,
  parameter int DISP_W = 12
) (
  input  logic [DATA_W-1:0] base_v,
  input  logic [DATA_W-1:0] index_v,
  input  logic [DISP_W-1:0] disp,
  output logic [DATA_W-1:0] sum
);
  localparam int PAD_W = DATA_W - DISP_W;
  always_comb sum = base_v + index_v + {{PAD_W{1'b0}}, disp};
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_W  = 4,
  parameter int DISP_W = 12,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  output logic [REG_W-1:0]  rd_base_idx,
  input  logic [ADDR_W-1:0] rd_base_data,
  output logic [REG_W-1:0]  rd_idx_idx,
  input  logic [ADDR_W-1:0] rd_idx_data,
  output logic              out_valid,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [CNT_W-1:0]  shift_cnt,
  output logic              is_address,
  output logic              is_count,
  output logic              illegal,
  output logic [1:0]        fmt,
  output logic [REG_W-1:0]  r1_fld,
  output logic [REG_W-1:0]  r2_fld,
  output logic [REG_W-1:0]  base_fld
);
  localparam int BASE_LSB = DISP_W;
  localparam int IDX_LSB  = DISP_W + REG_W;
  localparam int R1_LSB   = DISP_W + 2 * REG_W;
  localparam int OP_LSB   = DISP_W + 3 * REG_W;

  logic [7:0]        opcode;
  logic [REG_W-1:0]  f_r1, f_x, f_b;
  logic [DISP_W-1:0] f_disp;
  dec_t              dec;
  logic [ADDR_W-1:0] base_v, index_v, sum;

  assign opcode = instr[OP_LSB +: 8];
  assign f_r1   = instr[R1_LSB +: REG_W];
  assign f_x    = instr[IDX_LSB +: REG_W];
  assign f_b    = instr[BASE_LSB +: REG_W];
  assign f_disp = instr[0 +: DISP_W];

  assign rd_base_idx = f_b;
  assign rd_idx_idx  = f_x;

  eag_decode u_dec (.opcode(opcode), .dec(dec));

  eag_operand #(.DATA_W(ADDR_W), .REG_W(REG_W)) u_base (
    .fld(f_b), .en(1'b1), .data(rd_base_data), .val(base_v));

  eag_operand #(.DATA_W(ADDR_W), .REG_W(REG_W)) u_index (
    .fld(f_x), .en(dec.use_index), .data(rd_idx_data), .val(index_v));

  eag_sum #(.DATA_W(ADDR_W), .DISP_W(DISP_W)) u_sum (
    .base_v(base_v), .index_v(index_v), .disp(f_disp), .sum(sum));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      eff_addr   <= '0;
      shift_cnt  <= '0;
      is_address <= 1'b0;
      is_count   <= 1'b0;
      illegal    <= 1'b0;
      fmt        <= 2'b00;
      r1_fld     <= '0;
      r2_fld     <= '0;
      base_fld   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fmt        <= dec.fmt;
        r1_fld     <= f_r1;
        r2_fld     <= f_x;
        base_fld   <= f_b;
        illegal    <= dec.bad_op;
        is_count   <= !dec.bad_op && dec.is_shift;
        is_address <= !dec.bad_op && !dec.is_shift;
        eff_addr   <= (dec.bad_op || dec.is_shift) ? '0 : sum;
        shift_cnt  <= (!dec.bad_op && dec.is_shift) ? sum[CNT_W-1:0] : '0;
      end
    end
  end

  assert_strobe_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_no_stray_valid_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(eff_addr) && $stable(shift_cnt) && $stable(fmt)));
  assert_one_kind_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({is_address, is_count, illegal}) == 1));
  assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (eff_addr == '0 && shift_cnt == '0 && fmt == 2'b00));
  assert_count_no_addr_R8: assert property (@(posedge clk) disable iff (rst)
    is_count |-> (eff_addr == '0));
  assert_addr_no_count_R11: assert property (@(posedge clk) disable iff (rst)
    is_address |-> (shift_cnt == '0));
  assert_reset_clear_R10: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && eff_addr == '0 && !illegal));
endmodule

// File: tb/test_eff_addr_gen.sv
module test_eff_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [3:0]  rd_base_idx, rd_idx_idx;
  logic [31:0] rd_base_data, rd_idx_data;
  logic        out_valid, is_address, is_count, illegal;
  logic [31:0] eff_addr;
  logic [5:0]  shift_cnt;
  logic [1:0]  fmt;
  logic [3:0]  r1_fld, r2_fld, base_fld;

  logic [31:0] gpr [16];
  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  assign rd_base_data = gpr[rd_base_idx];
  assign rd_idx_data  = gpr[rd_idx_idx];

  eff_addr_gen i_eff_addr_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .rd_base_idx(rd_base_idx), .rd_base_data(rd_base_data),
    .rd_idx_idx(rd_idx_idx), .rd_idx_data(rd_idx_data),
    .out_valid(out_valid), .eff_addr(eff_addr), .shift_cnt(shift_cnt),
    .is_address(is_address), .is_count(is_count), .illegal(illegal),
    .fmt(fmt), .r1_fld(r1_fld), .r2_fld(r2_fld), .base_fld(base_fld));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Drive one strobed word, result is registered at the next edge.
  task automatic issue(logic [31:0] w);
    @(negedge clk);
    instr = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Expected result from the requirements.
  task automatic expect_word(string req, logic [31:0] w);
    logic [7:0]  op;
    logic [3:0]  x, b;
    logic [31:0] s;
    logic        rx, rs, sh, bad;
    op = w[31:24]; x = w[19:16]; b = w[15:12];
    rx = (op == 8'h58);
    sh = (op == 8'h89);
    rs = (op == 8'h98) || sh;
    bad = !(rx || rs);
    s = ((b != 0) ? gpr[b] : 32'd0) + ((rx && x != 0) ? gpr[x] : 32'd0) + {20'd0, w[11:0]};
    chk(req, "out_valid", {31'd0, out_valid}, 32'd1);
    chk(req, "eff_addr", eff_addr, (bad || sh) ? 32'd0 : s);
    chk(req, "shift_cnt", {26'd0, shift_cnt}, sh ? {26'd0, s[5:0]} : 32'd0);
    chk(req, "kind", {29'd0, is_address, is_count, illegal},
        {29'd0, !bad && !sh, sh, bad});
    chk(req, "fmt", {30'd0, fmt}, rx ? 32'd1 : (rs ? 32'd2 : 32'd0));
    chk("R2", "fields", {20'd0, r1_fld, r2_fld, base_fld}, {20'd0, w[23:12]});
  endtask

  task automatic t_reset;
    chk("R10", "out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10", "eff_addr", eff_addr, 32'd0);
    chk("R10", "flags", {26'd0, shift_cnt, is_address, is_count, illegal, fmt[0]}, 32'd0);
  endtask

  task automatic t_ports_R2;
    @(negedge clk);
    instr = 32'h5873A000;
    #1;
    chk("R2", "rd_base_idx", {28'd0, rd_base_idx}, 32'hA);
    chk("R2", "rd_idx_idx", {28'd0, rd_idx_idx}, 32'h3);
  endtask

  task automatic t_example_R7;
    gpr[12] = 32'h00002500;
    issue(32'h5840C123);
    chk("R7", "example ea", eff_addr, 32'h00002623);
    expect_word("R7", 32'h5840C123);
    issue(32'h98579100);
    expect_word("R7", 32'h98579100);
  endtask

  task automatic t_zero_fields_R4_R5;
    gpr[0] = 32'hDEAD0000;
    issue(32'h58400ABC);
    chk("R4", "absolute disp", eff_addr, 32'h00000ABC);
    gpr[5] = 32'h100;
    issue(32'h58405FFF);
    chk("R5", "index zero", eff_addr, 32'h000010FF);
  endtask

  task automatic t_index_R3;
    gpr[3] = 32'h00010000; gpr[5] = 32'h00000200;
    issue(32'h58135010);
    chk("R3", "b+x+d", eff_addr, 32'h00010210);
    gpr[9] = 32'hFFFFFFFF; gpr[2] = 32'h2;
    issue(32'h58029FFF);
    chk("R3", "wrap", eff_addr, 32'h00001000);
  endtask

  task automatic t_same_reg_R3;
    gpr[7] = 32'h01000001;
    issue(32'h58177004);
    chk("R3", "same reg twice", eff_addr, 32'h02000006);
  endtask

  task automatic t_rs_R6;
    gpr[11] = 32'h7FFF0000; gpr[4] = 32'h40;
    issue(32'h985B4001);
    chk("R6", "second nibble ignored", eff_addr, 32'h00000041);
    expect_word("R6", 32'h985B4001);
  endtask

  task automatic t_shift_R8;
    issue(32'h89400001);
    chk("R8", "count 1", {26'd0, shift_cnt}, 32'd1);
    gpr[8] = 32'd3;
    issue(32'h89408000);
    chk("R8", "count 3", {26'd0, shift_cnt}, 32'd3);
    chk("R8", "no address", eff_addr, 32'd0);
    gpr[8] = 32'h45;
    issue(32'h89408000);
    chk("R8", "low six bits", {26'd0, shift_cnt}, 32'd5);
  endtask

  task automatic t_illegal_R9;
    issue(32'h12345678);
    expect_word("R9", 32'h12345678);
  endtask

  task automatic t_hold_R1;
    logic [31:0] keep;
    issue(32'h5840C010);
    keep = eff_addr;
    @(negedge clk);
    instr = 32'h12000000;
    @(negedge clk);
    chk("R1", "no strobe valid", {31'd0, out_valid}, 32'd0);
    chk("R1", "held ea", eff_addr, keep);
    chk("R11", "address count zero", {26'd0, shift_cnt}, 32'd0);
  endtask

  task automatic t_random;
    logic [7:0] ops [4];
    ops[0] = 8'h58; ops[1] = 8'h98; ops[2] = 8'h89; ops[3] = 8'h07;
    for (int k = 0; k < 16; k++) gpr[k] = $urandom;
    for (int n = 0; n < 60; n++) begin
      logic [31:0] w;
      w = $urandom;
      w[31:24] = ops[$urandom % 4];
      if (n % 5 == 0) w[15:12] = 4'd0;
      if (n % 7 == 0) w[19:16] = 4'd0;
      if (n % 3 == 0) w[11:0] = 12'hFFF;
      issue(w);
      expect_word("R3", w);
    end
  endtask

  initial begin
    for (int k = 0; k < 16; k++) gpr[k] = 32'd0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_ports_R2();
    t_example_R7();
    t_zero_fields_R4_R5();
    t_index_R3();
    t_same_reg_R3();
    t_rs_R6();
    t_shift_R8();
    t_illegal_R9();
    t_hold_R1();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule